// File: doc/BRIEF.md
# Fine-Step Oversampling and Bit Clock Generator

This block makes the master oversampling clock for an external audio converter and, from that clock, the serial bit clock that the block drives when it is the timing master of the serial link. A phase accumulator advances by a programmable increment on every system clock. Its most significant bit is the oversampling clock, so the output frequency is `f_sys * increment / 2^ACC_W`. With the default 32-bit accumulator and a 200 MHz system clock, one step is about 0.047 Hz and the top frequency is 40 MHz, which covers the usual 256x and 384x sample-rate multiples.

An integer divider follows the accumulator. It counts rising edges of the oversampling clock and toggles the bit clock after every half of the programmed divide value. The divide value is always even and lies between 2 and `DIV_MAX`, so the bit clock never runs faster than half the oversampling clock. That keeps it at or below 20 MHz. Each clock has a one-cycle rise strobe and a one-cycle fall strobe in the system clock domain, for use by a serializer. Software writes the increment and the divide value through two write strobes. A single enable starts both clocks from phase zero and stops them.

Top module: `osc_clk_gen`

## Requirements
- R1: After reset, all six outputs are low, the increment register is 0 and the divide value is `DIV_RST`. Enabling the block without writing an increment leaves every output low.
- R2: While the block is enabled, the accumulator advances by the increment on each system clock and `osclk` is its most significant bit. Over 2^ACC_W cycles from enable, `osclk` therefore rises exactly `increment` times.
- R3: An increment write above `INC_LIMIT = floor(OSC_MAX_HZ * 2^ACC_W / SYS_HZ)` is stored as `INC_LIMIT` in the default clamping variant. In the rejecting variant it is ignored.
- R4: A written increment is used from the accumulator update one cycle after the write cycle, and the write does not reset the accumulator phase.
- R5: `bclk` starts low and toggles one cycle after every (N/2)-th `osclk` rise strobe, where N is the divide value. `div_wdata` carries N as a plain binary number.
- R6: A divide write is accepted only when N is even and 2 <= N <= `DIV_MAX`. Any other value is ignored and the previous N stays in force.
- R7: While `enable` is low, the accumulator and the divider are held at zero. `osclk`, `bclk` and all strobes are low from the cycle after `enable` is seen low. Re-enabling restarts from phase zero.
- R8: `osclk_rise`/`osclk_fall` and `bclk_rise`/`bclk_fall` are high for exactly the one cycle in which the matching clock first shows its new level. The rise and fall strobes of one clock are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Runs both clocks when high; holds them at zero when low |
| inc_we | input | 1 | Write strobe for the frequency increment |
| inc_wdata | input | ACC_W | Frequency increment value |
| div_we | input | 1 | Write strobe for the bit clock divide value |
| div_wdata | input | DIV_W | Divide value N (binary) |
| osclk | output | 1 | Oversampling clock (accumulator MSB) |
| osclk_rise | output | 1 | One-cycle strobe on an `osclk` rising edge |
| osclk_fall | output | 1 | One-cycle strobe on an `osclk` falling edge |
| bclk | output | 1 | Serial bit clock, `osclk` divided by N |
| bclk_rise | output | 1 | One-cycle strobe on a `bclk` rising edge |
| bclk_fall | output | 1 | One-cycle strobe on a `bclk` falling edge |

## Verification
The hardest case to reach from the ports is an increment change while the accumulator is mid-phase. A bug that clears the phase on a write, or that applies the new step one cycle early, changes only a few `osclk` edges afterwards. The bench runs the clock for an odd number of cycles so that the accumulator sits at an arbitrary phase, writes the new increment, and then compares every cycle against an arithmetic phase sequence. The same cycle-exact comparison covers divide writes with illegal values issued while the bit clock is running. It also covers a sweep of every legal increment, and of every legal divide value, on an 8-bit accumulator, where a full phase cycle lasts only 256 clocks.

// File: rtl/osc_gen_pkg.sv
package osc_gen_pkg;

   typedef struct packed {
      logic rise;
      logic fall;
   } edge_strb_t;

   // A divide value is usable when it is even and within 2..lim
   function automatic bit div_legal(input int unsigned n, input int unsigned lim);
      return (n >= 2) && (n <= lim) && (n % 2 == 0);
   endfunction

   // Largest increment whose output stays at or below max_hz
   function automatic longint unsigned inc_ceiling(input int acc_w,
                                                   input longint unsigned max_hz,
                                                   input longint unsigned sys_hz);
      return (max_hz << acc_w) / sys_hz;
   endfunction

endpackage

// File: rtl/osc_edge_strobe.sv
module osc_edge_strobe (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en,
   input  logic                    level,
   output osc_gen_pkg::edge_strb_t strb
);
   logic level_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !en) level_q <= 1'b0;
      else               level_q <= level;
   end

   always_comb begin
      strb.rise = level & ~level_q;
      strb.fall = ~level & level_q;
   end
endmodule

// File: rtl/osc_phase_acc.sv
module osc_phase_acc #(
   parameter int ACC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [ACC_W-1:0] inc,
   output logic             msb
);
   logic [ACC_W-1:0] phase_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !en) phase_q <= '0;
      else               phase_q <= phase_q + inc;
   end

   assign msb = phase_q[ACC_W-1];
endmodule

// File: rtl/osc_bclk_div.sv
module osc_bclk_div #(
   parameter int HALF_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              tick,
   input  logic [HALF_W-1:0] half,
   output logic              bclk
);
   logic [HALF_W-1:0] cnt_q;
   logic [HALF_W:0]   cnt_nxt;

   assign cnt_nxt = {1'b0, cnt_q} + (HALF_W+1)'(1);

   always_ff @(posedge clk) begin
      if (!rst_n || !en) begin
         cnt_q <= '0;
         bclk  <= 1'b0;
      end else if (tick) begin
         // ">=" recovers cleanly when the half period shrinks mid-count
         if (cnt_nxt >= {1'b0, half}) begin
            cnt_q <= '0;
            bclk  <= ~bclk;
         end else begin
            cnt_q <= cnt_nxt[HALF_W-1:0];
         end
      end
   end
endmodule

// File: rtl/osc_reg_file.sv
module osc_reg_file #(
   parameter int              ACC_W     = 32,
   parameter int              DIV_W     = 9,
   parameter int              DIV_MAX   = 256,
   parameter int              DIV_RST   = 4,
   parameter longint unsigned INC_LIMIT = 1,
   parameter bit              CLAMP_INC = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_we,
   input  logic [ACC_W-1:0] inc_wdata,
   input  logic             div_we,
   input  logic [DIV_W-1:0] div_wdata,
   output logic [ACC_W-1:0] inc_q,
   output logic [DIV_W-2:0] div_half_q
);
   localparam logic [ACC_W-1:0] LIM      = ACC_W'(INC_LIMIT);
   localparam logic [DIV_W-2:0] HALF_RST = (DIV_W-1)'(DIV_RST / 2);

   logic [ACC_W-1:0] inc_next;
   logic             inc_ok;
   logic             div_ok;

   generate
      if (CLAMP_INC) begin : g_clamp
         assign inc_next = (inc_wdata > LIM) ? LIM : inc_wdata;
         assign inc_ok   = 1'b1;
      end else begin : g_reject
         assign inc_next = inc_wdata;
         assign inc_ok   = (inc_wdata <= LIM);
      end
   endgenerate

   assign div_ok = osc_gen_pkg::div_legal(32'(div_wdata), DIV_MAX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         inc_q      <= '0;
         div_half_q <= HALF_RST;
      end else begin
         if (inc_we && inc_ok) inc_q      <= inc_next;
         if (div_we && div_ok) div_half_q <= div_wdata[DIV_W-1:1];
      end
   end
endmodule

// File: rtl/osc_clk_gen.sv
module osc_clk_gen #(
   parameter int              ACC_W      = 32,
   parameter longint unsigned SYS_HZ     = 200_000_000,
   parameter longint unsigned OSC_MAX_HZ = 40_000_000,
   parameter int              DIV_MAX    = 256,
   parameter int              DIV_W      = $clog2(DIV_MAX) + 1,
   parameter int              DIV_RST    = 4,
   parameter bit              CLAMP_INC  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             inc_we,
   input  logic [ACC_W-1:0] inc_wdata,
   input  logic             div_we,
   input  logic [DIV_W-1:0] div_wdata,
   output logic             osclk,
   output logic             osclk_rise,
   output logic             osclk_fall,
   output logic             bclk,
   output logic             bclk_rise,
   output logic             bclk_fall
);
   localparam int              HALF_W    = DIV_W - 1;
   localparam longint unsigned INC_LIMIT =
      osc_gen_pkg::inc_ceiling(ACC_W, OSC_MAX_HZ, SYS_HZ);

   generate
      if (ACC_W < 4 || ACC_W > 36) begin : g_bad_acc_w
         $error("osc_clk_gen: ACC_W must be within 4..36");
      end
      if (SYS_HZ < 2 * OSC_MAX_HZ) begin : g_bad_rate
         $error("osc_clk_gen: SYS_HZ must be at least twice OSC_MAX_HZ");
      end
      if (DIV_MAX < 2 || (DIV_MAX % 2) != 0) begin : g_bad_div_max
         $error("osc_clk_gen: DIV_MAX must be even and at least 2");
      end
      if (DIV_W != $clog2(DIV_MAX) + 1) begin : g_bad_div_w
         $error("osc_clk_gen: DIV_W does not match DIV_MAX");
      end
      if (!osc_gen_pkg::div_legal(DIV_RST, DIV_MAX)) begin : g_bad_div_rst
         $error("osc_clk_gen: DIV_RST is not a legal divide value");
      end
      if (INC_LIMIT == 0) begin : g_bad_limit
         $error("osc_clk_gen: OSC_MAX_HZ is below one frequency step");
      end
   endgenerate

   logic [ACC_W-1:0]        inc_q;
   logic [HALF_W-1:0]       div_half_q;
   osc_gen_pkg::edge_strb_t os_strb;
   osc_gen_pkg::edge_strb_t bc_strb;

   osc_reg_file #(
      .ACC_W     (ACC_W),
      .DIV_W     (DIV_W),
      .DIV_MAX   (DIV_MAX),
      .DIV_RST   (DIV_RST),
      .INC_LIMIT (INC_LIMIT),
      .CLAMP_INC (CLAMP_INC)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .inc_we     (inc_we),
      .inc_wdata  (inc_wdata),
      .div_we     (div_we),
      .div_wdata  (div_wdata),
      .inc_q      (inc_q),
      .div_half_q (div_half_q)
   );

   osc_phase_acc #(.ACC_W(ACC_W)) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (enable),
      .inc   (inc_q),
      .msb   (osclk)
   );

   osc_edge_strobe u_os_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (enable),
      .level (osclk),
      .strb  (os_strb)
   );

   osc_bclk_div #(.HALF_W(HALF_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (enable),
      .tick  (os_strb.rise),
      .half  (div_half_q),
      .bclk  (bclk)
   );

   osc_edge_strobe u_bc_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (enable),
      .level (bclk),
      .strb  (bc_strb)
   );

   assign osclk_rise = os_strb.rise;
   assign osclk_fall = os_strb.fall;
   assign bclk_rise  = bc_strb.rise;
   assign bclk_fall  = bc_strb.fall;
endmodule

// File: rtl/osc_clk_gen_chk.sv
module osc_clk_gen_chk #(
   parameter int              ACC_W     = 32,
   parameter int              HALF_W    = 8,
   parameter int              DIV_MAX   = 256,
   parameter longint unsigned INC_LIMIT = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              enable,
   input logic [ACC_W-1:0]  inc_q,
   input logic [HALF_W-1:0] div_half_q,
   input logic              osclk,
   input logic              osclk_rise,
   input logic              osclk_fall,
   input logic              bclk,
   input logic              bclk_rise,
   input logic              bclk_fall
);
   localparam logic [ACC_W-1:0] LIM = ACC_W'(INC_LIMIT);

   // R3: the stored increment never exceeds the frequency ceiling
   a_r3_inc_within_limit: assert property (@(posedge clk) disable iff (!rst_n)
      inc_q <= LIM);

   // R6: only legal half periods are ever held
   a_r6_div_half_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (div_half_q >= HALF_W'(1)) && (int'(div_half_q) <= DIV_MAX / 2));

   // R7: outputs go low once enable is seen low
   a_r7_off_clocks_low: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!osclk && !bclk && !osclk_rise && !bclk_rise));

   // R8: a rise strobe marks a genuine low-to-high step of osclk
   a_r8_osclk_rise_edge: assert property (@(posedge clk) disable iff (!rst_n)
      osclk_rise |-> (osclk && !$past(osclk)));

   // R8: bit clock strobes are mutually exclusive
   a_r8_bclk_strobes_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({bclk_rise, bclk_fall, osclk_rise && osclk_fall}));

   // R5: a running bit clock only moves one cycle after an osclk rise strobe
   a_r5_bclk_moves_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(enable) && (bclk != $past(bclk))) |-> $past(osclk_rise));
endmodule

bind osc_clk_gen osc_clk_gen_chk #(
   .ACC_W     (ACC_W),
   .HALF_W    (HALF_W),
   .DIV_MAX   (DIV_MAX),
   .INC_LIMIT (INC_LIMIT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .enable     (enable),
   .inc_q      (inc_q),
   .div_half_q (div_half_q),
   .osclk      (osclk),
   .osclk_rise (osclk_rise),
   .osclk_fall (osclk_fall),
   .bclk       (bclk),
   .bclk_rise  (bclk_rise),
   .bclk_fall  (bclk_fall)
);

// File: tb/sim_osc_clk_gen.sv
module sim_osc_clk_gen;
   localparam int CLK_PERIOD = 10;
   localparam int AW    = 8;
   localparam int DMAX  = 16;
   localparam int DW    = 5;
   localparam int DRST  = 4;
   localparam int LIMIT = 102;   // floor(40 * 256 / 100)

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          enable = 1'b0;
   logic          inc_we = 1'b0;
   logic [AW-1:0] inc_wdata = '0;
   logic          div_we = 1'b0;
   logic [DW-1:0] div_wdata = '0;
   logic osclk, osclk_rise, osclk_fall, bclk, bclk_rise, bclk_fall;

   always #(CLK_PERIOD/2) clk = ~clk;

   osc_clk_gen #(
      .ACC_W(AW), .SYS_HZ(100), .OSC_MAX_HZ(40),
      .DIV_MAX(DMAX), .DIV_W(DW), .DIV_RST(DRST), .CLAMP_INC(1'b1)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .inc_we(inc_we), .inc_wdata(inc_wdata),
      .div_we(div_we), .div_wdata(div_wdata),
      .osclk(osclk), .osclk_rise(osclk_rise), .osclk_fall(osclk_fall),
      .bclk(bclk), .bclk_rise(bclk_rise), .bclk_fall(bclk_fall)
   );

   int checks = 0;
   int fails  = 0;

   // arithmetic expectation
   int m_acc, m_inc, m_half, m_rises;
   bit m_msb, m_orise, m_ofall, m_bclk, m_brise, m_bfall;

   // window bookkeeping
   int         w_err, w_rises;
   logic [5:0] w_act, w_exp;

   function automatic logic [5:0] outs();
      return {osclk, osclk_rise, osclk_fall, bclk, bclk_rise, bclk_fall};
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      m_acc = 0; m_inc = 0; m_half = DRST / 2; m_rises = 0;
      m_msb = 0; m_orise = 0; m_ofall = 0;
      m_bclk = 0; m_brise = 0; m_bfall = 0;
   endtask

   task automatic win_start();
      w_err = 0; w_rises = 0; w_act = '0; w_exp = '0;
   endtask

   task automatic step();
      bit   p_msb, p_bclk;
      int   r_before;
      logic [5:0] exp_v, act_v;
      @(posedge clk);
      if (enable) begin
         r_before = m_rises;
         p_msb    = m_msb;
         p_bclk   = m_bclk;
         m_acc    = (m_acc + m_inc) % (1 << AW);
         m_msb    = ((m_acc >> (AW-1)) & 1) != 0;
         m_orise  = m_msb & ~p_msb;
         m_ofall  = ~m_msb & p_msb;
         m_rises  = m_rises + int'(m_orise);
         m_bclk   = ((r_before / m_half) % 2) != 0;
         m_brise  = m_bclk & ~p_bclk;
         m_bfall  = ~m_bclk & p_bclk;
      end else begin
         m_acc = 0; m_rises = 0;
         m_msb = 0; m_orise = 0; m_ofall = 0;
         m_bclk = 0; m_brise = 0; m_bfall = 0;
      end
      if (inc_we) m_inc = (int'(inc_wdata) > LIMIT) ? LIMIT : int'(inc_wdata);
      if (div_we && int'(div_wdata) >= 2 && int'(div_wdata) <= DMAX && div_wdata[0] == 1'b0)
         m_half = int'(div_wdata) / 2;
      @(negedge clk);
      inc_we = 1'b0;
      div_we = 1'b0;
      exp_v = {m_msb, m_orise, m_ofall, m_bclk, m_brise, m_bfall};
      act_v = outs();
      if (act_v !== exp_v) begin
         if (w_err == 0) begin
            w_act = act_v;
            w_exp = exp_v;
         end
         w_err++;
      end
      if (osclk_rise === 1'b1) w_rises++;
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic configure(input int inc, input int n);
      enable    = 1'b0;
      inc_we    = 1'b1; inc_wdata = AW'(inc);
      div_we    = 1'b1; div_wdata = DW'(n);
      step();
      enable = 1'b1;
      win_start();
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      model_reset();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: all outputs low straight after reset
      check("R1 outputs after reset", int'(outs()), 0);
      rst_n = 1'b1;

      // R1: reset increment is zero, so an enabled block stays quiet
      enable = 1'b1;
      win_start();
      run(40);
      check("R1 enabled with reset increment", int'(w_act), int'(w_exp));
      check("R1 no osclk rises with reset increment", w_rises, 0);

      // R1 R5: reset divide value DRST applies when only the increment is written
      inc_we = 1'b1; inc_wdata = AW'(37);
      win_start();
      run(300);
      check("R1 R5 reset divide value waveform", int'(w_act), int'(w_exp));

      // R2 R5 R8: sweep every legal increment, cycling through all divide values
      for (int inc = 1; inc <= LIMIT; inc++) begin
         configure(inc, 2 + 2 * (inc % (DMAX / 2)));
         run(1 << AW);
         check($sformatf("R2 R5 R8 waveform inc=%0d", inc), int'(w_act), int'(w_exp));
         check($sformatf("R2 rise count inc=%0d", inc), w_rises, inc);
      end

      // R3: increments above the ceiling are clamped
      configure(200, 2);
      run(1 << AW);
      check("R3 clamp waveform inc=200", int'(w_act), int'(w_exp));
      check("R3 clamp rise count inc=200", w_rises, LIMIT);
      configure(255, 16);
      run(1 << AW);
      check("R3 clamp rise count inc=255", w_rises, LIMIT);

      // R4: increment change mid-phase keeps the phase and applies next cycle
      configure(10, 4);
      run(37);
      inc_we = 1'b1; inc_wdata = AW'(50);
      step();
      run(120);
      check("R4 mid-run increment change", int'(w_act), int'(w_exp));
      inc_we = 1'b1; inc_wdata = AW'(3);
      step();
      run(200);
      check("R4 second increment change", int'(w_act), int'(w_exp));

      // R6: illegal divide writes while running are ignored
      configure(61, 6);
      run(23);
      for (int k = 0; k < 6; k++) begin
         div_we = 1'b1;
         case (k)
            0: div_wdata = DW'(7);
            1: div_wdata = DW'(0);
            2: div_wdata = DW'(1);
            3: div_wdata = DW'(18);
            4: div_wdata = DW'(31);
            default: div_wdata = DW'(15);
         endcase
         step();
      end
      run(150);
      check("R6 illegal divide values ignored", int'(w_act), int'(w_exp));
      check("R6 rise count unaffected", w_rises > 0 ? 1 : 0, 1);

      // R7: disable mid-run forces everything low, re-enable restarts at phase zero
      configure(77, 4);
      run(45);
      enable = 1'b0;
      step();
      check("R7 outputs low after disable", int'(outs()), 0);
      run(3);
      check("R7 outputs stay low", int'(outs()), 0);
      enable = 1'b1;
      win_start();
      run(200);
      check("R7 restart from phase zero", int'(w_act), int'(w_exp));

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule